// File: doc/BRIEF.md
# Translation Front End with Address-Space Selection and Prefix Relocation

This block sits in front of a multi-level table walker in a 64-bit address translation path. It accepts one request at a time: a logical address, an access kind (read, write or instruction fetch), an address-space mode and a translation-enable bit. It aligns the address to its 4 KiB page and starts from full read, write and execute permission. When translation is enabled, it picks one of three table-designation control words and hands the request to the walker through a start/done handshake. When translation is disabled, it uses the aligned address directly as the real address. The walker's permission vector is narrowed by a mode-dependent mask.

The real address then passes through prefix relocation. The low 8 KiB window and the 8 KiB window at the prefix value trade places, and all other addresses pass through unchanged. The resulting absolute address is compared with the installed memory size. The block pulses a done flag and holds its result until the next request is accepted. An unusable mode or a walker fault ends the request with a fault flag set.

Top module: `xlat_front`

## Requirements
- R1: On acceptance, the page-offset bits [11:0] of `req_laddr` are cleared before use. The walker receives the cleared address in `walk_vaddr`. Permission starts as all granted, with bit 0 = read, bit 1 = write and bit 2 = execute.
- R2: With `req_xlat_en` = 0, no `walk_start` is issued and the real address is the page-aligned logical address, with permission 3'b111. The mode is not examined in this case.
- R3: Mode 2'b00 (primary) walks with `cr_primary` and mode 2'b11 (home) walks with `cr_home`. `walk_start` is a single-cycle pulse one cycle after acceptance, and `walk_kind` equals `req_kind` (0 read, 1 write, 2 fetch).
- R4: In mode 2'b10 (secondary), a fetch (kind 2) walks with `cr_primary`. The result permission is the walker permission with the read and write bits cleared.
- R5: In mode 2'b10, a data access (kind 0 or 1) walks with `cr_secondary`. The result permission is the walker permission with the execute bit cleared. In modes 2'b00 and 2'b11, the walker permission is passed through unchanged.
- R6: A real address below 0x2000 becomes the prefix value plus the address.
- R7: A real address not below 0x2000, at or above `prefix` and below `prefix`+0x2000 becomes the address minus the prefix. Every other real address is passed through unchanged.
- R8: `rsp_in_range` is 1 exactly when a non-faulting absolute address is at or below `mem_size`.
- R9: With translation enabled, mode 2'b01 ends the request without a walk and sets `rsp_fault` and `rsp_mode_err`.
- R10: When `walk_fault` is set with `walk_done`, the result has `rsp_fault` = 1, `rsp_mode_err` = 0, `rsp_abs` = 0, `rsp_perm` = 0 and `rsp_in_range` = 0.
- R11: `rsp_done` is a one-cycle pulse in the cycle after the result is formed. The result outputs stay unchanged until the next pulse, and `req_ready` is low while a walk is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted when `req_ready` is high |
| req_ready | output | 1 | Block idle and able to accept |
| req_laddr | input | 64 | Logical address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_mode | input | 2 | Address-space mode: 00 primary, 01 unusable, 10 secondary, 11 home |
| req_xlat_en | input | 1 | Translation enable |
| cr_primary | input | 64 | Primary table designation |
| cr_secondary | input | 64 | Secondary table designation |
| cr_home | input | 64 | Home table designation |
| prefix | input | 64 | Prefix value for low-window relocation |
| mem_size | input | 64 | Installed memory size bound |
| walk_start | output | 1 | One-cycle walk request |
| walk_desig | output | 64 | Chosen table designation |
| walk_vaddr | output | 64 | Page-aligned logical address for the walk |
| walk_kind | output | 2 | Access kind passed to the walker |
| walk_done | input | 1 | Walker finished |
| walk_fault | input | 1 | Walker reported a fault |
| walk_raddr | input | 64 | Real address from the walker |
| walk_perm | input | 3 | Permission from the walker (bit0 R, bit1 W, bit2 X) |
| rsp_done | output | 1 | Result pulse |
| rsp_fault | output | 1 | Request faulted |
| rsp_mode_err | output | 1 | Fault caused by an unusable mode |
| rsp_abs | output | 64 | Absolute address |
| rsp_perm | output | 3 | Final permission (bit0 R, bit1 W, bit2 X) |
| rsp_in_range | output | 1 | Absolute address within memory size |

## Verification
The assertions check on every cycle that the done pulse lasts one cycle, that the results hold between pulses, and that the walk start is a single pulse. They also check that bypassed or mode-error requests never start a walk, that secondary-mode fetches never keep read or write permission, and that a faulted result carries no permission or range flag. The bench scenarios show the behaviour that depends on values. These cover which designation each mode and kind selects, the exact relocation at the edges of both 8 KiB windows, the boundary of the memory-size comparison, and the page alignment seen by the walker.

// File: rtl/xf_pkg.sv
package xf_pkg;
  localparam int ADDR_W = 64;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [2:0]        perm_t;

  typedef enum logic [1:0] {
    ASM_PRIMARY   = 2'b00,
    ASM_UNUSABLE  = 2'b01,
    ASM_SECONDARY = 2'b10,
    ASM_HOME      = 2'b11
  } as_mode_e;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam perm_t PERM_R   = 3'b001;
  localparam perm_t PERM_W   = 3'b010;
  localparam perm_t PERM_X   = 3'b100;
  localparam perm_t PERM_ALL = 3'b111;

  function automatic addr_t page_align(addr_t a, int unsigned pbits);
    addr_t m;
    m = '1;
    m = m << pbits;
    return a & m;
  endfunction

  function automatic addr_t relocate(addr_t r, addr_t pfx, addr_t win);
    if (r < win)                          return pfx + r;
    else if (r >= pfx && r < pfx + win)   return r - pfx;
    else                                  return r;
  endfunction

  function automatic perm_t keep_mask(as_mode_e m, logic [1:0] kind);
    if (m == ASM_SECONDARY)
      return (kind == ACC_FETCH) ? PERM_X : (PERM_R | PERM_W);
    return PERM_ALL;
  endfunction
endpackage

// File: rtl/xf_desig_sel.sv
module xf_desig_sel
  import xf_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [1:0]    mode,
  input  logic [1:0]    kind,
  input  logic [AW-1:0] cr_pri,
  input  logic [AW-1:0] cr_sec,
  input  logic [AW-1:0] cr_hom,
  output logic [AW-1:0] desig,
  output perm_t         keep,
  output logic          mode_bad
);
  as_mode_e m;
  assign m = as_mode_e'(mode);

  always_comb begin
    desig    = cr_pri;
    mode_bad = 1'b0;
    unique case (m)
      ASM_PRIMARY:   desig = cr_pri;
      ASM_HOME:      desig = cr_hom;
      ASM_SECONDARY: desig = (kind == ACC_FETCH) ? cr_pri : cr_sec;
      default:       mode_bad = 1'b1;
    endcase
  end

  assign keep = keep_mask(m, kind);

  always_comb begin
    a_fetch_mask_r4: assert (!(m == ASM_SECONDARY && kind == ACC_FETCH) || keep == PERM_X);
  end
endmodule

// File: rtl/xf_prefix.sv
module xf_prefix
  import xf_pkg::*;
#(
  parameter int AW       = ADDR_W,
  parameter int WIN_BITS = 13
) (
  input  logic [AW-1:0] real_addr,
  input  logic [AW-1:0] pfx,
  input  logic [AW-1:0] mem_size,
  output logic [AW-1:0] abs_addr,
  output logic          in_range
);
  localparam addr_t WIN = addr_t'(1) << WIN_BITS;

  assign abs_addr = relocate(real_addr, pfx, WIN);
  assign in_range = (abs_addr <= mem_size);
endmodule

// File: rtl/xlat_front.sv
module xlat_front
  import xf_pkg::*;
#(
  parameter int PAGE_BITS = 12,
  parameter int WIN_BITS  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_laddr,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_mode,
  input  logic              req_xlat_en,
  input  logic [63:0]       cr_primary,
  input  logic [63:0]       cr_secondary,
  input  logic [63:0]       cr_home,
  input  logic [63:0]       prefix,
  input  logic [63:0]       mem_size,
  output logic              walk_start,
  output logic [63:0]       walk_desig,
  output logic [63:0]       walk_vaddr,
  output logic [1:0]        walk_kind,
  input  logic              walk_done,
  input  logic              walk_fault,
  input  logic [63:0]       walk_raddr,
  input  logic [2:0]        walk_perm,
  output logic              rsp_done,
  output logic              rsp_fault,
  output logic              rsp_mode_err,
  output logic [63:0]       rsp_abs,
  output logic [2:0]        rsp_perm,
  output logic              rsp_in_range
);
  typedef enum logic {ST_IDLE, ST_WALK} st_e;
  st_e st;

  addr_t laddr_pg;
  addr_t sel_desig;
  perm_t sel_keep;
  logic  sel_bad;
  perm_t keep_q;
  logic  sec_fetch_q;

  assign laddr_pg = page_align(req_laddr, PAGE_BITS);

  xf_desig_sel #(.AW(ADDR_W)) u_sel (
    .mode(req_mode), .kind(req_kind),
    .cr_pri(cr_primary), .cr_sec(cr_secondary), .cr_hom(cr_home),
    .desig(sel_desig), .keep(sel_keep), .mode_bad(sel_bad)
  );

  // Named events used by the FSM and the assertions
  logic accept, fin_bypass, fin_moderr, fin_walk, fin, fin_fault;
  assign req_ready  = (st == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign fin_bypass = accept && !req_xlat_en;
  assign fin_moderr = accept && req_xlat_en && sel_bad;
  assign fin_walk   = (st == ST_WALK) && walk_done;
  assign fin        = fin_bypass || fin_moderr || fin_walk;
  assign fin_fault  = fin_moderr || (fin_walk && walk_fault);

  addr_t fin_real, fin_abs;
  perm_t fin_perm;
  logic  fin_inr;
  assign fin_real = fin_walk ? walk_raddr : laddr_pg;
  assign fin_perm = fin_walk ? (walk_perm & keep_q) : PERM_ALL;

  xf_prefix #(.AW(ADDR_W), .WIN_BITS(WIN_BITS)) u_pfx (
    .real_addr(fin_real), .pfx(prefix), .mem_size(mem_size),
    .abs_addr(fin_abs), .in_range(fin_inr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      walk_start  <= 1'b0;
      walk_desig  <= '0;
      walk_vaddr  <= '0;
      walk_kind   <= '0;
      keep_q      <= PERM_ALL;
      sec_fetch_q <= 1'b0;
    end else begin
      walk_start <= 1'b0;
      if (accept && req_xlat_en && !sel_bad) begin
        st          <= ST_WALK;
        walk_start  <= 1'b1;
        walk_desig  <= sel_desig;
        walk_vaddr  <= laddr_pg;
        walk_kind   <= req_kind;
        keep_q      <= sel_keep;
        sec_fetch_q <= (req_mode == ASM_SECONDARY) && (req_kind == ACC_FETCH);
      end else if (fin_walk) begin
        st <= ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_done     <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_mode_err <= 1'b0;
      rsp_abs      <= '0;
      rsp_perm     <= '0;
      rsp_in_range <= 1'b0;
    end else begin
      rsp_done <= fin;
      if (fin) begin
        rsp_fault    <= fin_fault;
        rsp_mode_err <= fin_moderr;
        rsp_abs      <= fin_fault ? '0 : fin_abs;
        rsp_perm     <= fin_fault ? '0 : fin_perm;
        rsp_in_range <= fin_fault ? 1'b0 : fin_inr;
      end
    end
  end

  p_bypass_nowalk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fin_bypass |=> !walk_start);
  p_moderr_nowalk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin_moderr |=> (!walk_start && rsp_fault && rsp_mode_err));
  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |=> !walk_start);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_hold_abs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_done |-> ($stable(rsp_abs) && $stable(rsp_perm) && $stable(rsp_fault)));
  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |-> !req_ready);
  p_sec_fetch_perm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_walk && sec_fetch_q) |=> (rsp_perm[1:0] == 2'b00));
  p_fault_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fault) |-> (rsp_perm == 3'b000 && !rsp_in_range && rsp_abs == '0));
endmodule

// File: tb/tb_xlat_front.sv
`timescale 1ns/1ps
module tb_xlat_front;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic req_valid = 0, req_ready, req_xlat_en = 0;
  logic [63:0] req_laddr = 0;
  logic [1:0] req_kind = 0, req_mode = 0;
  logic [63:0] cr_primary = 64'hAAAA_0000_0000_1001;
  logic [63:0] cr_secondary = 64'hBBBB_0000_0000_2002;
  logic [63:0] cr_home = 64'hCCCC_0000_0000_3003;
  logic [63:0] prefix = 64'h0004_0000;
  logic [63:0] mem_size = 64'h1_0000_0000;
  logic walk_start, walk_done = 0, walk_fault = 0;
  logic [63:0] walk_desig, walk_vaddr, walk_raddr = 0;
  logic [1:0] walk_kind;
  logic [2:0] walk_perm = 0;
  logic rsp_done, rsp_fault, rsp_mode_err, rsp_in_range;
  logic [63:0] rsp_abs;
  logic [2:0] rsp_perm;

  xlat_front dut (.*);

  int checks = 0, fails = 0, starts = 0;
  bit summary_done = 0;

  always @(posedge clk) if (rst_n && walk_start) starts++;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_map(logic [63:0] r, logic [63:0] p);
    logic [63:0] d;
    d = r - p;
    if (r[63:13] == 51'd0) return r + p;
    if (r >= p && d < 64'h2000) return d;
    return r;
  endfunction

  // One request; if walk expected, act as walker and check the hand-off.
  task automatic run(input logic [63:0] la, input logic [1:0] kind, input logic [1:0] mode,
                     input logic en, input bit do_walk, input logic [63:0] exp_desig,
                     input logic [63:0] raddr, input logic [2:0] wperm, input logic wfault,
                     input string tag);
    int s0;
    s0 = starts;
    @(negedge clk);
    req_valid = 1; req_laddr = la; req_kind = kind; req_mode = mode; req_xlat_en = en;
    @(negedge clk);
    req_valid = 0;
    if (do_walk) begin
      for (int i = 0; i < 10 && !walk_start; i++) @(negedge clk);
      chk({tag, " walk_start"}, walk_start, 1);
      chk({tag, " desig"}, walk_desig, exp_desig);
      chk({tag, " vaddr R1"}, walk_vaddr, {la[63:12], 12'h000});
      chk({tag, " kind R3"}, walk_kind, kind);
      chk({tag, " busy R11"}, req_ready, 0);
      walk_done = 1; walk_fault = wfault; walk_raddr = raddr; walk_perm = wperm;
      @(negedge clk);
      walk_done = 0; walk_fault = 0;
    end else begin
      chk({tag, " no walk"}, starts, s0);
    end
    for (int i = 0; i < 10 && !rsp_done; i++) @(negedge clk);
    chk({tag, " done"}, rsp_done, 1);
  endtask

  task automatic t_reset;
    chk("R11 reset done", rsp_done, 0);
    chk("R11 reset ready", req_ready, 1);
    chk("R3 reset start", walk_start, 0);
    chk("R11 reset abs", rsp_abs, 0);
  endtask

  task automatic t_bypass_far;
    run(64'h0123_4567_89AB_CDEF, 2'd0, 2'b01, 0, 0, 0, 0, 0, 0, "R2 bypass");
    chk("R1 R2 abs aligned", rsp_abs, 64'h0123_4567_89AB_C000);
    chk("R1 perm all", rsp_perm, 3'b111);
    chk("R2 no mode err", rsp_fault, 0);
    chk("R8 out of range", rsp_in_range, 0);
  endtask

  task automatic t_prefix_edges;
    run(64'h1FFF, 0, 0, 0, 0, 0, 0, 0, 0, "R6 low");
    chk("R6 low window", rsp_abs, model_map(64'h1000, prefix));
    chk("R6 low window lit", rsp_abs, 64'h41000);
    run(64'h0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 zero");
    chk("R6 zero", rsp_abs, 64'h40000);
    run(64'h41ABC, 0, 0, 0, 0, 0, 0, 0, 0, "R7 swap");
    chk("R7 swap window", rsp_abs, 64'h1000);
    run(64'h42000, 0, 0, 0, 0, 0, 0, 0, 0, "R7 above");
    chk("R7 above window", rsp_abs, 64'h42000);
    run(64'h2000, 0, 0, 0, 0, 0, 0, 0, 0, "R7 mid");
    chk("R7 just past low", rsp_abs, 64'h2000);
    run(64'h3F000, 0, 0, 0, 0, 0, 0, 0, 0, "R7 below");
    chk("R7 just below prefix", rsp_abs, 64'h3F000);
  endtask

  task automatic t_modes;
    run(64'h0070_1234, 2'd1, 2'b00, 1, 1, cr_primary, 64'h50_0000, 3'b011, 0, "R3 primary");
    chk("R3 primary abs", rsp_abs, 64'h50_0000);
    chk("R5 primary perm", rsp_perm, 3'b011);
    chk("R8 in range", rsp_in_range, 1);
    run(64'h0080_0FFF, 2'd0, 2'b11, 1, 1, cr_home, 64'h1000, 3'b101, 0, "R3 home");
    chk("R3 home abs via R6", rsp_abs, 64'h41000);
    chk("R5 home perm", rsp_perm, 3'b101);
    run(64'h0090_0000, 2'd2, 2'b10, 1, 1, cr_primary, 64'h60_0000, 3'b111, 0, "R4 sec fetch");
    chk("R4 sec fetch perm", rsp_perm, 3'b100);
    run(64'h0090_0000, 2'd0, 2'b10, 1, 1, cr_secondary, 64'h60_0000, 3'b111, 0, "R5 sec read");
    chk("R5 sec read perm", rsp_perm, 3'b011);
    run(64'h0090_0000, 2'd1, 2'b10, 1, 1, cr_secondary, 64'h60_0000, 3'b110, 0, "R5 sec write");
    chk("R5 sec write perm", rsp_perm, 3'b010);
  endtask

  task automatic t_faults;
    run(64'h1234_5000, 2'd0, 2'b01, 1, 0, 0, 0, 0, 0, "R9 bad mode");
    chk("R9 fault", rsp_fault, 1);
    chk("R9 mode err", rsp_mode_err, 1);
    run(64'h7000, 2'd1, 2'b00, 1, 1, cr_primary, 64'h7000, 3'b111, 1, "R10 walk fault");
    chk("R10 fault", rsp_fault, 1);
    chk("R10 mode err clear", rsp_mode_err, 0);
    chk("R10 perm", rsp_perm, 0);
    chk("R10 abs", rsp_abs, 0);
    chk("R10 range", rsp_in_range, 0);
  endtask

  task automatic t_range_and_hold;
    mem_size = 64'h0123_0000;
    run(64'h0123_0000, 0, 0, 0, 0, 0, 0, 0, 0, "R8 edge");
    chk("R8 equal in range", rsp_in_range, 1);
    run(64'h0123_1000, 0, 0, 0, 0, 0, 0, 0, 0, "R8 over");
    chk("R8 above out", rsp_in_range, 0);
    repeat (3) @(negedge clk);
    chk("R11 done pulse", rsp_done, 0);
    chk("R11 hold abs", rsp_abs, 64'h0123_1000);
    mem_size = 64'h1_0000_0000;
  endtask

  task automatic summary;
    if (!summary_done) begin
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bypass_far();
    t_prefix_edges();
    t_modes();
    t_faults();
    t_range_and_hold();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule